// File: doc/BRIEF.md
# Three-Read, One-Write Synchronous Register Array with Write Forwarding

This block stores 64 operand registers of 64 bits each. The lower half of the address space holds the integer registers and the upper half holds the floating-point registers. Three read ports take their addresses from an early decode stage. Each port returns its data one clock later, so the storage can map onto a synchronous block memory. One write port, fed from writeback, updates a single entry per cycle.

Each read port latches its address. While the pipeline is stalled, the latched addresses are read again, so the outputs stay current as writes land. The write that takes place at a clock edge is also held for one cycle. Each port compares that held write against its own latched address and forwards the new value when they match. This means a read issued in the same cycle as a write to the same entry returns the new data.

A debug agent can read one entry. It does this by taking over read port B in a cycle when decode does not need that port. A small controller handles this with three states:
- `DBG_IDLE`: no request is open. A request moves the controller to `DBG_WAIT`.
- `DBG_WAIT`: the request is held until a free port-B slot is taken. That transition is the grant, and it moves the controller to `DBG_READ`.
- `DBG_READ`: the result is presented for one cycle, then the controller returns to `DBG_IDLE`.

Top module: `opreg_array`

## Requirements
- R1: The 6-bit address selects one of 64 independent 64-bit entries. Integer register n is at address n, and floating-point register n is at address 32+n. Every entry, including 0, 31, 32 and 63, holds its own value.
- R2: When stall is low, each of the three read ports shows, one cycle after its address is applied, the content of the addressed entry. Each port uses its own address.
- R3: While stall is high, each port ignores its address input and rereads the address it latched last. Its output reflects any write made to that entry.
- R4: A read issued in the same cycle as a write (wr_en high) to the same address returns the newly written data on every port that reads it.
- R5: With wr_en low, wr_addr and wr_data have no effect on any entry.
- R6: A debug read is granted port B only in a cycle where b_busy is low and stall is low. Until then, the request stays pending and dbg_valid stays low.
- R7: After a grant, dbg_valid is high for exactly one cycle, in the cycle after the grant, and dbg_data then holds the requested entry. A dbg_req that arrives while a request is open is ignored.
- R8: After reset, all three read outputs are zero and dbg_valid is low. The held write and the latched addresses are also cleared. The array contents are undefined.
- R9: While a debug request waits and b_busy is high, port B keeps returning the instruction operand addressed by rd_b_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Replay the latched read addresses |
| rd_a_addr | input | 6 | Read port A address |
| rd_b_addr | input | 6 | Read port B address |
| rd_c_addr | input | 6 | Read port C address |
| b_busy | input | 1 | The current instruction needs port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 64 | Write data |
| dbg_req | input | 1 | Debug read request (one-cycle pulse) |
| dbg_addr | input | 6 | Debug read address, sampled with dbg_req |
| rd_a_data | output | 64 | Read port A data |
| rd_b_data | output | 64 | Read port B data |
| rd_c_data | output | 64 | Read port C data |
| dbg_valid | output | 1 | Debug data valid |
| dbg_data | output | 64 | Debug read data |

## Verification
Read data is due exactly one rising edge after its address is applied. A forwarded value is due at that same edge, because the write that is held at that edge is the one the comparison uses. dbg_valid is due one edge after the grant cycle, so it comes at least two edges after the request. The bench drives all inputs just after a falling edge and checks all outputs at the following falling edge, which is half a period after the single rising edge that produced them. For multi-cycle behaviour, such as stall replay and a waiting debug request, the bench steps one cycle at a time and checks each cycle.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
    typedef enum logic [1:0] {
        DBG_IDLE = 2'd0,
        DBG_WAIT = 2'd1,
        DBG_READ = 2'd2
    } dbg_state_e;
endpackage

// File: rtl/opreg_store.sv
module opreg_store #(
    parameter int WIDTH  = 64,
    parameter int DEPTH  = 64,
    parameter int NPORTS = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [WIDTH-1:0]              wdata,
    input  logic [NPORTS-1:0][AW-1:0]     raddr,
    output logic [NPORTS-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[p] <= '0;
            end else begin
                rdata[p] <= mem[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/opreg_rdport.sv
module opreg_rdport #(
    parameter int WIDTH = 64,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [AW-1:0]    addr_in,
    output logic [AW-1:0]    addr_sel,
    input  logic             wq_en,
    input  logic [AW-1:0]    wq_addr,
    input  logic [WIDTH-1:0] wq_data,
    input  logic [WIDTH-1:0] mem_q,
    output logic [WIDTH-1:0] data_out
);
    logic [AW-1:0] addr_q;

    always_comb begin
        addr_sel = hold ? addr_q : addr_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_sel;
        end
    end

    always_comb begin
        if (wq_en && (wq_addr == addr_q)) begin
            data_out = wq_data;
        end else begin
            data_out = mem_q;
        end
    end

    assert_hold_keeps_addr_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/opreg_dbg_ctrl.sv
module opreg_dbg_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic          slot_free,
    output logic          grant,
    output logic [AW-1:0] grant_addr,
    output logic          valid
);
    import opreg_pkg::*;

    dbg_state_e    state, state_nx;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DBG_IDLE;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == DBG_IDLE && req) begin
                addr_q <= req_addr;
            end
        end
    end

    always_comb begin
        state_nx   = state;
        grant      = 1'b0;
        valid      = 1'b0;
        grant_addr = addr_q;
        unique case (state)
            DBG_IDLE: begin
                if (req) state_nx = DBG_WAIT;
            end
            DBG_WAIT: begin
                if (slot_free) begin
                    grant    = 1'b1;
                    state_nx = DBG_READ;
                end
            end
            DBG_READ: begin
                valid    = 1'b1;
                state_nx = DBG_IDLE;
            end
            default: state_nx = DBG_IDLE;
        endcase
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_valid_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(grant));
endmodule

// File: rtl/opreg_array.sv
module opreg_array #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int NP   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic [AW-1:0]    rd_b_addr,
    input  logic [AW-1:0]    rd_c_addr,
    input  logic             b_busy,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             dbg_req,
    input  logic [AW-1:0]    dbg_addr,
    output logic [WIDTH-1:0] rd_a_data,
    output logic [WIDTH-1:0] rd_b_data,
    output logic [WIDTH-1:0] rd_c_data,
    output logic             dbg_valid,
    output logic [WIDTH-1:0] dbg_data
);
    logic                     wq_en;
    logic [AW-1:0]            wq_addr;
    logic [WIDTH-1:0]         wq_data;
    logic                     grant;
    logic [AW-1:0]            grant_addr;
    logic [NP-1:0][AW-1:0]    addr_in;
    logic [NP-1:0][AW-1:0]    addr_sel;
    logic [NP-1:0][WIDTH-1:0] mem_q;
    logic [NP-1:0][WIDTH-1:0] port_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            wq_en   <= 1'b0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            wq_en   <= wr_en;
            wq_addr <= wr_addr;
            wq_data <= wr_data;
        end
    end

    opreg_dbg_ctrl #(.AW(AW)) u_dbg (
        .clk        (clk),
        .rst        (rst),
        .req        (dbg_req),
        .req_addr   (dbg_addr),
        .slot_free  (!b_busy && !stall),
        .grant      (grant),
        .grant_addr (grant_addr),
        .valid      (dbg_valid)
    );

    always_comb begin
        addr_in[0] = rd_a_addr;
        addr_in[1] = grant ? grant_addr : rd_b_addr;
        addr_in[2] = rd_c_addr;
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        opreg_rdport #(.WIDTH(WIDTH), .AW(AW)) u_port (
            .clk      (clk),
            .rst      (rst),
            .hold     (stall),
            .addr_in  (addr_in[p]),
            .addr_sel (addr_sel[p]),
            .wq_en    (wq_en),
            .wq_addr  (wq_addr),
            .wq_data  (wq_data),
            .mem_q    (mem_q[p]),
            .data_out (port_out[p])
        );
    end

    opreg_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NPORTS(NP)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (addr_sel),
        .rdata (mem_q)
    );

    assign rd_a_data = port_out[0];
    assign rd_b_data = port_out[1];
    assign rd_c_data = port_out[2];
    assign dbg_data  = port_out[1];

    assert_same_cycle_forward_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stall) && $past(wr_en) && ($past(rd_a_addr) == $past(wr_addr)))
        |-> (rd_a_data == $past(wr_data)));
    assert_dbg_free_slot_R6: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |-> $past(!b_busy && !stall));
endmodule

// File: tb/opreg_array_test.sv
module opreg_array_test;
    localparam int W = 64;
    localparam int AW = 6;
    localparam int NV = 8;

    localparam logic [AW-1:0] VADDR [NV] = '{6'd0, 6'd31, 6'd32, 6'd63, 6'd5, 6'd17, 6'd40, 6'd12};
    localparam logic [W-1:0]  VDATA [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'h3FF0_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D,
        64'h0000_0000_0000_0055, 64'h8000_0000_0000_0001,
        64'h5A5A_A5A5_5A5A_A5A5, 64'h0000_FFFF_0000_FFFF};

    logic clk = 1'b0;
    logic rst, stall, b_busy, wr_en, dbg_req;
    logic [AW-1:0] rd_a_addr, rd_b_addr, rd_c_addr, wr_addr, dbg_addr;
    logic [W-1:0]  wr_data, rd_a_data, rd_b_data, rd_c_data, dbg_data;
    logic dbg_valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    opreg_array uut (
        .clk(clk), .rst(rst), .stall(stall),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_c_addr(rd_c_addr),
        .b_busy(b_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dbg_req(dbg_req), .dbg_addr(dbg_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_c_data(rd_c_data),
        .dbg_valid(dbg_valid), .dbg_data(dbg_data));

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] newv;
        rst = 1'b1; stall = 1'b0; b_busy = 1'b1; wr_en = 1'b0; dbg_req = 1'b0;
        rd_a_addr = '0; rd_b_addr = '0; rd_c_addr = '0;
        wr_addr = '0; wr_data = '0; dbg_addr = '0;
        step(); step();
        // R8: reset state
        check("R8 rd_a after reset", rd_a_data, '0);
        check("R8 rd_b after reset", rd_b_data, '0);
        check("R8 rd_c after reset", rd_c_data, '0);
        check("R8 dbg_valid after reset", {63'd0, dbg_valid}, '0);
        rst = 1'b0;

        // R1: fill the table, one write per cycle
        for (int i = 0; i < NV; i++) begin
            wr_en = 1'b1; wr_addr = VADDR[i]; wr_data = VDATA[i];
            step();
        end
        wr_en = 1'b0;

        // R1 R2: read back, three ports with different addresses
        for (int i = 0; i < NV; i++) begin
            rd_a_addr = VADDR[i];
            rd_b_addr = VADDR[(i + 1) % NV];
            rd_c_addr = VADDR[(i + 2) % NV];
            step();
            check($sformatf("R1 R2 port A vec %0d", i), rd_a_data, VDATA[i]);
            check($sformatf("R2 port B vec %0d", i), rd_b_data, VDATA[(i + 1) % NV]);
            check($sformatf("R2 port C vec %0d", i), rd_c_data, VDATA[(i + 2) % NV]);
        end

        // R4: write and read of entry 5 in the same cycle
        newv = 64'hB1B2_B3B4_B5B6_B7B8;
        wr_en = 1'b1; wr_addr = 6'd5; wr_data = newv;
        rd_a_addr = 6'd5; rd_b_addr = 6'd5; rd_c_addr = 6'd5;
        step();
        check("R4 forward port A", rd_a_data, newv);
        check("R4 forward port B", rd_b_data, newv);
        check("R4 forward port C", rd_c_data, newv);

        // R5: disabled write to entry 5 does nothing
        wr_en = 1'b0; wr_data = 64'h1111_2222_3333_4444;
        step();
        check("R5 disabled write same cycle", rd_a_data, newv);
        step();
        check("R5 disabled write next cycle", rd_a_data, newv);

        // R3: stall replays latched address, sees writes
        rd_a_addr = VADDR[0];
        step();
        check("R3 pre-stall read", rd_a_data, VDATA[0]);
        stall = 1'b1; rd_a_addr = VADDR[1];
        wr_en = 1'b1; wr_addr = VADDR[0]; wr_data = 64'h7777_8888_9999_AAAA;
        step();
        check("R3 stall replay with write", rd_a_data, 64'h7777_8888_9999_AAAA);
        wr_en = 1'b0;
        step();
        check("R3 stall replay from array", rd_a_data, 64'h7777_8888_9999_AAAA);
        stall = 1'b0;
        step();
        check("R3 release stall takes new address", rd_a_data, VDATA[1]);

        // R6 R7 R9: debug read of entry 63
        b_busy = 1'b1; rd_b_addr = VADDR[1];
        dbg_req = 1'b1; dbg_addr = 6'd63;
        step();
        check("R6 no grant while busy", {63'd0, dbg_valid}, '0);
        check("R9 port B keeps operand", rd_b_data, VDATA[1]);
        dbg_addr = 6'd0;
        step();
        dbg_req = 1'b0;
        check("R6 still pending", {63'd0, dbg_valid}, '0);
        check("R9 port B keeps operand again", rd_b_data, VDATA[1]);
        b_busy = 1'b0; stall = 1'b1;
        step();
        check("R6 no grant while stalled", {63'd0, dbg_valid}, '0);
        stall = 1'b0;
        step();
        check("R7 dbg_valid after grant", {63'd0, dbg_valid}, 64'd1);
        check("R7 dbg_data first request", dbg_data, VDATA[3]);
        b_busy = 1'b1;
        step();
        check("R7 dbg_valid single cycle", {63'd0, dbg_valid}, '0);
        step();
        check("R7 ignored second request", {63'd0, dbg_valid}, '0);

        finish_run();
    end
endmodule